// File: doc/BRIEF.md
# Interleave Address Dehash Stage

This block undoes the channel-select hashing that a memory fabric applies to a normalized physical address. It supports interleave arrangements whose total channel count is a power of two from 1 to 16, with a granularity of either 1 KiB or 2 KiB. From the channel count and the granularity it derives a set of candidate bit positions among 8, 9, 12, 13 and 14. Each selected position is flipped when the exclusive-OR of its higher-order source bits is 1. Only the source bits whose page-size hash level is enabled take part, and there are four levels: 64 KiB, 2 MiB, 1 GiB and 1 TiB.

The unit also screens the interleave setup it is given. A configuration it cannot handle raises an error flag, and the address then passes through unchanged. The result is held in one output register with a valid/ready handshake, so an address-translation pipeline can stall it.

Top module: `dhx_dehash_unit`

## Requirements
- R1: The candidate vector is (C-1) shifted left by 8, where C is the channel count. With 1K granularity (`in_gran_1k`=1), two zero bits are opened at bit 10. With 2K granularity, three zero bits are opened at bit 9. As a result, 1K never touches bit 14, 2K never touches bit 9, and C=1 touches nothing.
- R2: A selected bit 8 is flipped by the XOR of bits 16, 21, 30 and 40. A selected bit 9 is flipped by the XOR of bits 17, 22, 31 and 41.
- R3: A selected bit 12 uses bits 18, 23, 32 and 42. Bit 13 uses bits 19, 24, 33 and 43. Bit 14 uses bits 20, 25, 34 and 44.
- R4: `in_hash_en` bit 0 enables the 64K term (the first source in each list). Bit 1 enables the 2M term, bit 2 the 1G term and bit 3 the 1T term. A cleared enable removes its term.
- R5: Address bits other than the selected candidates leave the block unchanged.
- R6: An interleave bit position other than 8, a socket count above 2 or a die count above 1 sets `out_err`. The address then passes through unchanged.
- R7: A channel count of zero, above 16 or not a power of two sets `out_err`. The address then passes through unchanged.
- R8: `in_ready` is high when the output register is empty or is being drained. The result appears on the cycle after acceptance and is held while `out_ready` is low.
- R9: While reset is asserted and right after it, `out_valid` is 0.
- R10: A socket count of 1 or 2 gives the same corrected address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_addr | input | 48 | Hashed address |
| in_chan_total | input | 5 | Total interleaved channel count |
| in_gran_1k | input | 1 | 1 = 1K granularity, 0 = 2K |
| in_hash_en | input | 4 | Hash level enables {1T,1G,2M,64K} |
| in_sockets | input | 3 | Interleaved socket count |
| in_dies | input | 3 | Interleaved die count |
| in_intlv_pos | input | 6 | Interleave start bit position |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream ready |
| out_addr | output | 48 | Dehashed address |
| out_err | output | 1 | Configuration rejected |

## Verification
The hardest case to reach from the ports is a candidate bit whose selection depends jointly on granularity and channel count. An example is bit 13, which is selected only at 16 channels with 1K granularity but already at 8 channels with 2K. A single set source bit can show that bit staying put in one case and flipping in the next. The directed table therefore pairs rows that differ only in count or granularity, each with exactly one source bit set, so that a selection error shows up as a single wrong bit. Random addresses and enable mixes are then compared against an equation-level model. That model also covers rejected configurations, which must pass the address through.

// File: rtl/dhx_pkg.sv
package dhx_pkg;
  // Number of correctable positions and hash levels
  localparam int DHX_TGTS = 5;
  localparam int DHX_LVLS = 4;
  // Width of the candidate window and bits of channel index (log2 of 16)
  localparam int DHX_WIN  = 16;
  localparam int CH_BITS  = 4;
  localparam int INTLV_START = 8;

  // Candidate k sits at 8,9,12,13,14
  function automatic int dhx_tgt_pos(input int k);
    return (k < 2) ? (8 + k) : (10 + k);
  endfunction

  // Source bit for level lvl (0=64K,1=2M,2=1G,3=1T) feeding candidate k
  function automatic int dhx_src_pos(input int lvl, input int k);
    int base;
    case (lvl)
      0:       base = 16;
      1:       base = 21;
      2:       base = 30;
      default: base = 40;
    endcase
    return base + k;
  endfunction
endpackage

// File: rtl/dhx_select.sv
module dhx_select
  import dhx_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [CNT_W-1:0]    chan_total,
  input  logic                gran_1k,
  output logic [DHX_TGTS-1:0] sel
);
  logic [CNT_W-1:0]   cnt_m1;
  logic [DHX_WIN-1:0] raw_vec;
  logic [DHX_WIN-1:0] vec_1k;
  logic [DHX_WIN-1:0] vec_2k;
  logic [DHX_WIN-1:0] gap_vec;

  assign cnt_m1  = chan_total - CNT_W'(1);
  assign raw_vec = DHX_WIN'(cnt_m1[CH_BITS-1:0]) << INTLV_START;
  // open the gap: two zeros at bit 10 or three zeros at bit 9
  assign vec_1k  = ((raw_vec >> 10) << 12) | (raw_vec & DHX_WIN'(16'h03FF));
  assign vec_2k  = ((raw_vec >> 9)  << 12) | (raw_vec & DHX_WIN'(16'h01FF));
  assign gap_vec = gran_1k ? vec_1k : vec_2k;

  for (genvar k = 0; k < DHX_TGTS; k++) begin : g_sel
    assign sel[k] = gap_vec[dhx_tgt_pos(k)];
  end
endmodule

// File: rtl/dhx_cfg_chk.sv
module dhx_cfg_chk #(
  parameter int CNT_W  = 5,
  parameter int SOCK_W = 3,
  parameter int DIE_W  = 3,
  parameter int POS_W  = 6
) (
  input  logic [CNT_W-1:0]  chan_total,
  input  logic [SOCK_W-1:0] sockets,
  input  logic [DIE_W-1:0]  dies,
  input  logic [POS_W-1:0]  intlv_pos,
  output logic              cfg_bad
);
  localparam int MAX_CHAN = 16;
  localparam int MAX_SOCK = 2;
  localparam int MAX_DIE  = 1;

  logic cnt_bad;
  logic topo_bad;

  assign cnt_bad  = (chan_total == '0)
                  || (chan_total > CNT_W'(MAX_CHAN))
                  || ((chan_total & (chan_total - CNT_W'(1))) != '0);
  assign topo_bad = (intlv_pos != POS_W'(dhx_pkg::INTLV_START))
                  || (sockets > SOCK_W'(MAX_SOCK))
                  || (dies > DIE_W'(MAX_DIE));
  assign cfg_bad  = cnt_bad || topo_bad;
endmodule

// File: rtl/dhx_bit_fix.sv
module dhx_bit_fix
  import dhx_pkg::*;
(
  input  logic [DHX_LVLS-1:0] src_bits,
  input  logic [DHX_LVLS-1:0] hash_en,
  input  logic                selected,
  output logic                flip
);
  logic [DHX_LVLS-1:0] term;

  for (genvar l = 0; l < DHX_LVLS; l++) begin : g_term
    assign term[l] = src_bits[l] & hash_en[l];
  end

  assign flip = selected & (^term);
endmodule

// File: rtl/dhx_dehash_unit.sv
module dhx_dehash_unit
  import dhx_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int CNT_W  = 5,
  parameter int SOCK_W = 3,
  parameter int DIE_W  = 3,
  parameter int POS_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [CNT_W-1:0]  in_chan_total,
  input  logic              in_gran_1k,
  input  logic [DHX_LVLS-1:0] in_hash_en,
  input  logic [SOCK_W-1:0] in_sockets,
  input  logic [DIE_W-1:0]  in_dies,
  input  logic [POS_W-1:0]  in_intlv_pos,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_err
);
  // reset synchronizer: asynchronous assert, synchronous release
  logic rst_q1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_q1     <= 1'b1;
      rst_sync_n <= rst_q1;
    end
  end

  logic [DHX_TGTS-1:0] sel;
  logic [DHX_TGTS-1:0] flip;
  logic                cfg_bad;
  logic [ADDR_W-1:0]   flip_mask;

  dhx_select #(.CNT_W(CNT_W)) u_sel (
    .chan_total (in_chan_total),
    .gran_1k    (in_gran_1k),
    .sel        (sel)
  );

  dhx_cfg_chk #(.CNT_W(CNT_W), .SOCK_W(SOCK_W), .DIE_W(DIE_W), .POS_W(POS_W)) u_cfg (
    .chan_total (in_chan_total),
    .sockets    (in_sockets),
    .dies       (in_dies),
    .intlv_pos  (in_intlv_pos),
    .cfg_bad    (cfg_bad)
  );

  for (genvar k = 0; k < DHX_TGTS; k++) begin : g_fix
    logic [DHX_LVLS-1:0] src_bits;
    for (genvar l = 0; l < DHX_LVLS; l++) begin : g_src
      assign src_bits[l] = in_addr[dhx_src_pos(l, k)];
    end
    dhx_bit_fix u_fix (
      .src_bits (src_bits),
      .hash_en  (in_hash_en),
      .selected (sel[k]),
      .flip     (flip[k])
    );
  end

  always_comb begin
    flip_mask = '0;
    for (int k = 0; k < DHX_TGTS; k++) begin
      flip_mask[dhx_tgt_pos(k)] = flip[k];
    end
  end

  // next state
  logic              load_en;
  logic              vld_nxt;
  logic [ADDR_W-1:0] addr_nxt;
  logic              err_nxt;
  logic              vld_q;
  logic [ADDR_W-1:0] addr_q;
  logic              err_q;

  assign in_ready = rst_sync_n && (!vld_q || out_ready);
  assign load_en  = in_valid && in_ready;

  always_comb begin
    addr_nxt = in_addr;
    err_nxt  = cfg_bad;
    if (!cfg_bad) begin
      addr_nxt = in_addr ^ flip_mask;
    end
    if (load_en) begin
      vld_nxt = 1'b1;
    end else if (out_ready) begin
      vld_nxt = 1'b0;
    end else begin
      vld_nxt = vld_q;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      addr_q <= addr_nxt;
      err_q  <= err_nxt;
    end
  end

  assign out_valid = vld_q;
  assign out_addr  = addr_q;
  assign out_err   = err_q;
endmodule

// File: rtl/dhx_dehash_chk.sv
module dhx_dehash_chk #(
  parameter int ADDR_W = 48,
  parameter int CNT_W  = 5,
  parameter int POS_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_addr,
  input logic [CNT_W-1:0]  in_chan_total,
  input logic              in_gran_1k,
  input logic [POS_W-1:0]  in_intlv_pos,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_err
);
  localparam logic [ADDR_W-1:0] CAND = {{(ADDR_W-15){1'b0}}, 15'h7300};

  logic take;
  assign take = in_valid && in_ready;

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_err)));

  // R8
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R6
  bad_pos_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_intlv_pos != POS_W'(8)) |=> (out_valid && out_err && out_addr == $past(in_addr)));

  // R7
  bad_count_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (in_chan_total == '0 || in_chan_total > CNT_W'(16)))
      |=> (out_err && out_addr == $past(in_addr)));

  // R5
  outside_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (((out_addr ^ $past(in_addr)) & ~CAND) == '0));

  // R1
  gran_1k_bit14_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_gran_1k) |=> (out_addr[14] == $past(in_addr[14])));

  // R1
  gran_2k_bit9_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_gran_1k) |=> (out_addr[9] == $past(in_addr[9])));
endmodule

bind dhx_dehash_unit dhx_dehash_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .POS_W(POS_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_addr       (in_addr),
  .in_chan_total (in_chan_total),
  .in_gran_1k    (in_gran_1k),
  .in_intlv_pos  (in_intlv_pos),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_addr      (out_addr),
  .out_err       (out_err)
);

// File: tb/dhx_dehash_unit_test.sv
module dhx_dehash_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready;
  logic [47:0] in_addr;
  logic [4:0]  in_chan_total;
  logic        in_gran_1k;
  logic [3:0]  in_hash_en;
  logic [2:0]  in_sockets, in_dies;
  logic [5:0]  in_intlv_pos;
  logic        out_valid, out_ready;
  logic [47:0] out_addr;
  logic        out_err;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dhx_dehash_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_chan_total(in_chan_total), .in_gran_1k(in_gran_1k),
    .in_hash_en(in_hash_en), .in_sockets(in_sockets), .in_dies(in_dies),
    .in_intlv_pos(in_intlv_pos), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_err(out_err)
  );

  typedef struct packed {
    logic [47:0] addr;
    logic [4:0]  chan;
    logic        g1k;
    logic [3:0]  en;
    logic [2:0]  sk;
    logic [2:0]  di;
    logic [5:0]  pos;
    logic [47:0] exp_addr;
    logic        exp_err;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{48'h0000_0001_0000, 5'd2,  1'b0, 4'h1, 3'd1, 3'd1, 6'd8, 48'h0000_0001_0100, 1'b0}, // R2 bit8 via 16
    '{48'h0000_0040_0000, 5'd4,  1'b1, 4'h2, 3'd1, 3'd1, 6'd8, 48'h0000_0040_0200, 1'b0}, // R2 bit9 via 22
    '{48'h0400_0000_0000, 5'd4,  1'b0, 4'h8, 3'd1, 3'd1, 6'd8, 48'h0400_0000_1000, 1'b0}, // R3 bit12 via 42
    '{48'h0002_0000_0000, 5'd8,  1'b1, 4'h4, 3'd1, 3'd1, 6'd8, 48'h0002_0000_0000, 1'b0}, // R1 bit13 not selected
    '{48'h0002_0000_0000, 5'd16, 1'b1, 4'h4, 3'd1, 3'd1, 6'd8, 48'h0002_0000_2000, 1'b0}, // R3 bit13 via 33
    '{48'h1000_0000_0000, 5'd16, 1'b0, 4'h8, 3'd1, 3'd1, 6'd8, 48'h1000_0000_4000, 1'b0}, // R3 bit14 via 44
    '{48'h1000_0000_0000, 5'd16, 1'b1, 4'h8, 3'd1, 3'd1, 6'd8, 48'h1000_0000_0000, 1'b0}, // R1 1K leaves bit14
    '{48'h0000_0010_0000, 5'd16, 1'b0, 4'h0, 3'd1, 3'd1, 6'd8, 48'h0000_0010_0000, 1'b0}, // R4 all disabled
    '{48'h0000_0010_0000, 5'd16, 1'b0, 4'h1, 3'd1, 3'd1, 6'd8, 48'h0000_0010_4000, 1'b0}, // R4 64K on
    '{48'h0000_0001_0100, 5'd2,  1'b0, 4'h1, 3'd1, 3'd1, 6'd8, 48'h0000_0001_0000, 1'b0}, // R2 clears set bit
    '{48'h0000_0021_0100, 5'd2,  1'b0, 4'h3, 3'd1, 3'd1, 6'd8, 48'h0000_0021_0100, 1'b0}, // R4 terms cancel
    '{48'h0100_0000_0000, 5'd1,  1'b0, 4'hF, 3'd1, 3'd1, 6'd8, 48'h0100_0000_0000, 1'b0}, // R1 one channel
    '{48'h0000_0001_0000, 5'd2,  1'b0, 4'h1, 3'd1, 3'd1, 6'd9, 48'h0000_0001_0000, 1'b1}, // R6 position
    '{48'h0000_0001_0000, 5'd2,  1'b0, 4'h1, 3'd3, 3'd1, 6'd8, 48'h0000_0001_0000, 1'b1}, // R6 sockets
    '{48'h0000_0001_0000, 5'd2,  1'b0, 4'h1, 3'd1, 3'd2, 6'd8, 48'h0000_0001_0000, 1'b1}, // R6 dies
    '{48'h0000_0005_0000, 5'd3,  1'b0, 4'h1, 3'd1, 3'd1, 6'd8, 48'h0000_0005_0000, 1'b1}, // R7 count 3
    '{48'h0000_0005_0000, 5'd0,  1'b0, 4'h1, 3'd1, 3'd1, 6'd8, 48'h0000_0005_0000, 1'b1}, // R7 count 0
    '{48'h0000_0005_0000, 5'd17, 1'b0, 4'h1, 3'd1, 3'd1, 6'd8, 48'h0000_0005_0000, 1'b1}, // R7 count 17
    '{48'h0000_0001_0000, 5'd2,  1'b0, 4'h1, 3'd2, 3'd1, 6'd8, 48'h0000_0001_0100, 1'b0}  // R10 two sockets
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // equation-level model of the requirements, returns {err, addr}
  function automatic logic [48:0] model(input logic [47:0] a, input logic [4:0] c, input logic g1k,
                                        input logic [3:0] en, input logic [2:0] sk,
                                        input logic [2:0] di, input logic [5:0] pos);
    logic [47:0] r;
    logic [31:0] v;
    logic h;
    int tgt [5] = '{8, 9, 12, 13, 14};
    int base [4] = '{16, 21, 30, 40};
    if (pos != 6'd8 || sk > 3'd2 || di > 3'd1 || c == 5'd0 || c > 5'd16 || (c & (c - 5'd1)) != 5'd0)
      return {1'b1, a};
    v = (32'(c) - 32'd1) << 8;
    if (g1k) v = ((v >> 10) << 12) | (v & 32'h3FF);
    else     v = ((v >> 9) << 12) | (v & 32'h1FF);
    r = a;
    for (int j = 0; j < 5; j++) begin
      if (v[tgt[j]]) begin
        h = 1'b0;
        for (int l = 0; l < 4; l++) if (en[l]) h ^= a[base[l] + j];
        if (h) r[tgt[j]] = ~r[tgt[j]];
      end
    end
    return {1'b0, r};
  endfunction

  task automatic drive(input vec_t t);
    in_addr = t.addr; in_chan_total = t.chan; in_gran_1k = t.g1k; in_hash_en = t.en;
    in_sockets = t.sk; in_dies = t.di; in_intlv_pos = t.pos;
  endtask

  task automatic run_one(input vec_t t, input string req);
    @(negedge clk);
    drive(t);
    in_valid = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, {req, " valid"}, 64'(out_valid), 64'd1);
    check(out_addr == t.exp_addr, {req, " addr"}, 64'(out_addr), 64'(t.exp_addr));
    check(out_err == t.exp_err, {req, " err"}, 64'(out_err), 64'(t.exp_err));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    vec_t rv;
    logic [48:0] m;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    drive(TBL[0]);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9 in reset", 64'(out_valid), 64'd0);
    check(in_ready == 1'b0, "R9 ready in reset", 64'(in_ready), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9 after reset", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R8 ready idle", 64'(in_ready), 64'd1);

    for (int i = 0; i < NV; i++) begin
      run_one(TBL[i], $sformatf("table row %0d", i));
    end

    // R5 R1 R2 R3 R4 random addresses and enables against the model
    for (int i = 0; i < 300; i++) begin
      rv.addr = {16'($urandom), $urandom};
      rv.chan = (i % 7 == 6) ? 5'(3 + $urandom % 14) : 5'(1 << ($urandom % 5));
      rv.g1k  = 1'($urandom);
      rv.en   = 4'($urandom);
      rv.sk   = (i % 11 == 10) ? 3'd3 : 3'(1 + $urandom % 2);
      rv.di   = (i % 13 == 12) ? 3'd2 : 3'd1;
      rv.pos  = (i % 17 == 16) ? 6'd9 : 6'd8;
      m = model(rv.addr, rv.chan, rv.g1k, rv.en, rv.sk, rv.di, rv.pos);
      rv.exp_addr = m[47:0];
      rv.exp_err  = m[48];
      run_one(rv, "R5 random");
    end

    // R8 stall: result held while out_ready low, next one waits
    @(negedge clk);
    drive(TBL[0]); in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b1, "R8 stall valid", 64'(out_valid), 64'd1);
    check(in_ready == 1'b0, "R8 stall ready", 64'(in_ready), 64'd0);
    drive(TBL[2]);
    @(negedge clk);
    @(negedge clk);
    check(out_addr == TBL[0].exp_addr, "R8 stall hold", 64'(out_addr), 64'(TBL[0].exp_addr));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_addr == TBL[2].exp_addr, "R8 drain and accept", 64'(out_addr), 64'(TBL[2].exp_addr));
    check(out_valid == 1'b1, "R8 next valid", 64'(out_valid), 64'd1);
    @(negedge clk);
    check(out_valid == 1'b0, "R8 drained", 64'(out_valid), 64'd0);

    finish_run();
  end
endmodule